// File: doc/BRIEF.md
# Sparse Radix-3 Prefix Adder

This block adds two unsigned 64-bit operands and a carry-in and returns a 64-bit sum with a carry-out. It is purely combinational, so results follow the inputs with no clock and no state. It is meant to sit on a datapath where the add has to settle within a single cycle and the carry chain is the limiting path.

Carries come from a parallel-prefix tree in which every node merges three neighbouring spans. The tree produces only the carry into bits 2, 5, 8 and so on, every third position. The carry-in enters the tree as the generate term of an extra position just below bit 0, so every tree carry already includes it. While the tree settles, the operand bits are split into short groups: bits 1..0, then bits 4..2, 7..5 and so on, up to a final group of bits 63..62. Each group ripples two candidate results side by side, one for an incoming carry of 0 and one for 1. A 2:1 select for each group then picks the right candidate once its carry is known: the carry-in for the lowest group and a tree carry for every other group. The top group's candidates include their carry-outs, and the same select picks the adder's carry-out.

The tree has no fixed states or transitions; the logic depth is fixed. The 21 sparse carries need one leaf level of three-bit merges and three more merge levels. The group select adds one level, for five in all.

Top module: `sv3_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals the 65-bit value a + b + cin.
- R2: With both operands zero, sum equals cin (bit 0 set when cin is 1) and cout is 0.
- R3: The tree carry for position 3k+2 (k = 0..20) equals the true carry into that bit. The carry out of each select group equals the carry the tree hands to the next group up, so a carry stops or passes correctly at every group boundary.
- R4: When b is the bitwise complement of a, the result is all ones with cout 0 when cin is 0, and all zeros with cout 1 when cin is 1.
- R5: A carry entering at bit 0 travels the full width: all-ones plus zero with cin 1 gives sum 0 and cout 1.
- R6: Sum bits 1..0 depend only on a[1:0], b[1:0] and cin, whatever the upper operand bits hold.
- R7: The top group, bits 63..62, produces cout through the same select as its sum bits. For example, 2^63 + 2^63 gives sum 0 and cout 1.
- R8: Outputs depend only on the present inputs, with no storage. Zero inputs give zero outputs, and each new input vector is reflected within the same clock period.
- R9: Alternating bit patterns (0xAAAA... and 0x5555...) add correctly with both values of cin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First unsigned operand |
| b | input | 64 | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Low 64 bits of a + b + cin |
| cout | output | 1 | Carry out of bit 63 |

## Verification
The bound checker re-evaluates the adder whenever any input changes. It checks the whole 65-bit result against a reference add, the zero-operand and complement cases, and the fact that each tree carry matches both the carry implied by the sum bits and the carry-out of the group below it. That last check ties the tree and the select groups together at each of the 21 boundaries. The bench scenarios add what a single evaluation cannot show. One is the independence of the low two sum bits from the upper operand bits. Another is carries launched just below each group boundary and carries that ripple the whole width. A third is the top group's carry-out across directed and random vectors.

// File: rtl/sv3_pkg.sv
package sv3_pkg;

    // Number of radix-3 merge levels needed to span n elements.
    function automatic int clog3(input int n);
        int lv;
        int span;
        lv   = 0;
        span = 1;
        while (span < n) begin
            span = span * 3;
            lv   = lv + 1;
        end
        return lv;
    endfunction

    // 3 raised to e.
    function automatic int pow3(input int e);
        int r;
        r = 1;
        for (int i = 0; i < e; i++) r = r * 3;
        return r;
    endfunction

    // Generate term of a three-span merge; index 2 is the most significant span.
    function automatic logic gen3(input logic g2, input logic p2,
                                  input logic g1, input logic p1,
                                  input logic g0);
        return g2 | (p2 & g1) | (p2 & p1 & g0);
    endfunction

    // Propagate term of a three-span merge.
    function automatic logic prop3(input logic p2, input logic p1, input logic p0);
        return p2 & p1 & p0;
    endfunction

endpackage

// File: rtl/sv3_pg.sv
module sv3_pg #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] g,
    output logic [WIDTH-1:0] p
);
    // Bitwise generate and propagate; xor propagate doubles as the half-sum.
    assign g = a & b;
    assign p = a ^ b;
endmodule

// File: rtl/sv3_tree.sv
module sv3_tree
    import sv3_pkg::*;
#(
    parameter int NBLK = 21
) (
    input  logic [3*NBLK-2:0] g,
    input  logic [3*NBLK-2:0] p,
    input  logic              cin,
    output logic [NBLK-1:0]   carry
);
    localparam int EXTW = 3 * NBLK;
    localparam int LVL  = clog3(NBLK);

    // Extended vectors: position 0 is a virtual bit carrying cin as a generate.
    logic [EXTW-1:0] gx;
    logic [EXTW-1:0] px;
    assign gx = {g, cin};
    assign px = {p, 1'b0};

    logic [NBLK-1:0] gl [0:LVL];
    logic [NBLK-1:0] pl [0:LVL-1];

    // Leaf level: block k spans extended positions 3k+2..3k.
    for (genvar k = 0; k < NBLK; k++) begin : g_leaf
        assign gl[0][k] = gen3(gx[3*k+2], px[3*k+2], gx[3*k+1], px[3*k+1], gx[3*k]);
        assign pl[0][k] = prop3(px[3*k+2], px[3*k+1], px[3*k]);
    end

    // Kogge-Stone style merge levels with stride 3^(l-1).
    for (genvar l = 1; l <= LVL; l++) begin : g_lvl
        localparam int D = pow3(l - 1);
        for (genvar j = 0; j < NBLK; j++) begin : g_node
            if (j >= 2 * D) begin : g_full
                assign gl[l][j] = gen3(gl[l-1][j], pl[l-1][j],
                                       gl[l-1][j-D], pl[l-1][j-D],
                                       gl[l-1][j-2*D]);
                if (l < LVL) begin : g_p
                    assign pl[l][j] = prop3(pl[l-1][j], pl[l-1][j-D], pl[l-1][j-2*D]);
                end
            end else if (j >= D) begin : g_pair
                assign gl[l][j] = gen3(gl[l-1][j], pl[l-1][j],
                                       gl[l-1][j-D], pl[l-1][j-D], 1'b0);
                if (l < LVL) begin : g_p
                    assign pl[l][j] = prop3(pl[l-1][j], pl[l-1][j-D], 1'b1);
                end
            end else begin : g_pass
                assign gl[l][j] = gl[l-1][j];
                if (l < LVL) begin : g_p
                    assign pl[l][j] = pl[l-1][j];
                end
            end
        end
    end

    // Block k's prefix is the carry into bit 3k+2.
    assign carry = gl[LVL];
endmodule

// File: rtl/sv3_csel.sv
module sv3_csel #(
    parameter int GW = 3
) (
    input  logic [GW-1:0] g,
    input  logic [GW-1:0] p,
    output logic [GW-1:0] s0,
    output logic [GW-1:0] s1,
    output logic          co0,
    output logic          co1
);
    // Two short ripples run side by side: incoming carry 0 and incoming carry 1.
    always_comb begin : rip
        logic c0;
        logic c1;
        c0 = 1'b0;
        c1 = 1'b1;
        for (int i = 0; i < GW; i++) begin
            s0[i] = p[i] ^ c0;
            s1[i] = p[i] ^ c1;
            c0    = g[i] | (p[i] & c0);
            c1    = g[i] | (p[i] & c1);
        end
        co0 = c0;
        co1 = c1;
    end
endmodule

// File: rtl/sv3_adder.sv
module sv3_adder #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NBLK = (WIDTH - 3) / 3 + 1;
    localparam int NGRP = NBLK + 1;

    logic [WIDTH-1:0] g;
    logic [WIDTH-1:0] p;
    logic [NBLK-1:0]  tree_c;
    logic [NGRP-1:0]  gsel;
    logic [NGRP-1:0]  grp_co;

    sv3_pg #(.WIDTH(WIDTH)) u_pg (
        .a (a),
        .b (b),
        .g (g),
        .p (p)
    );

    sv3_tree #(.NBLK(NBLK)) u_tree (
        .g     (g[3*NBLK-2:0]),
        .p     (p[3*NBLK-2:0]),
        .cin   (cin),
        .carry (tree_c)
    );

    // Group 0 is chosen by cin, group k by the tree carry into bit 3k-1.
    assign gsel = {tree_c, cin};

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        localparam int LO = (k == 0) ? 0 : 3 * k - 1;
        localparam int HI = (k == 0) ? 1 : ((3 * k + 1 > WIDTH - 1) ? WIDTH - 1 : 3 * k + 1);
        localparam int GW = HI - LO + 1;
        logic [GW-1:0] s0;
        logic [GW-1:0] s1;
        logic          co0;
        logic          co1;

        sv3_csel #(.GW(GW)) u_cs (
            .g   (g[HI:LO]),
            .p   (p[HI:LO]),
            .s0  (s0),
            .s1  (s1),
            .co0 (co0),
            .co1 (co1)
        );

        assign sum[HI:LO] = gsel[k] ? s1 : s0;
        assign grp_co[k]  = gsel[k] ? co1 : co0;
    end

    assign cout = grp_co[NGRP-1];
endmodule

// File: rtl/sv3_adder_chk.sv
module sv3_adder_chk #(
    parameter int WIDTH = 64
) (
    input logic [WIDTH-1:0]             a,
    input logic [WIDTH-1:0]             b,
    input logic                         cin,
    input logic [WIDTH-1:0]             sum,
    input logic                         cout,
    input logic [(WIDTH-3)/3:0]         tree_c,
    input logic [(WIDTH-3)/3+1:0]       grp_co
);
    localparam int NBLK = (WIDTH - 3) / 3 + 1;

    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        assert_full_sum_R1: assert ({cout, sum} == ref_total)
            else $error("R1 result %h vs %h", {cout, sum}, ref_total);

        if (a == '0 && b == '0) begin
            assert_zero_ops_R2: assert (sum == {{(WIDTH-1){1'b0}}, cin} && !cout)
                else $error("R2 zero operands gave %h", sum);
        end

        if (b == ~a) begin
            assert_complement_R4: assert (sum == {WIDTH{~cin}} && cout == cin)
                else $error("R4 complement operands gave %h/%b", sum, cout);
        end

        if (a == '1 && b == '0 && cin) begin
            assert_full_ripple_R5: assert (sum == '0 && cout)
                else $error("R5 ripple gave %h/%b", sum, cout);
        end

        for (int k = 0; k < NBLK; k++) begin
            // Carry into bit 3k+2 recovered from the sum output.
            assert_tree_carry_R3: assert (tree_c[k] == (a[3*k+2] ^ b[3*k+2] ^ sum[3*k+2]))
                else $error("R3 tree carry %0d mismatch", k);
            // Select group k's chosen carry-out meets the tree carry of group k+1.
            assert_group_link_R3: assert (grp_co[k] == tree_c[k])
                else $error("R3 group %0d carry-out disagrees with tree", k);
        end
    end
endmodule

bind sv3_adder sv3_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a      (a),
    .b      (b),
    .cin    (cin),
    .sum    (sum),
    .cout   (cout),
    .tree_c (tree_c),
    .grp_co (grp_co)
);

// File: tb/sv3_adder_tb.sv
module sv3_adder_tb;
    localparam int W = 64;

    typedef struct {
        logic [W:0] exp;
        string      tag;
    } item_t;

    logic         clk = 1'b0;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    item_t q[$];

    always #4 clk = ~clk;

    sv3_adder #(.WIDTH(W)) u_dut (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    // Driver: new vector 1 ns after a rising edge, expected value queued.
    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic vc, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        a   = va;
        b   = vb;
        cin = vc;
        it.exp = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compares at the falling edge, mid-period.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if ({cout, sum} !== it.exp) begin
                bad++;
                $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h",
                         it.tag, a, b, cin, {cout, sum}, it.exp);
            end
        end
    end

    function automatic logic [W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        // R8: zero inputs, no storage, checked before any stimulus.
        #2;
        total++;
        if ({cout, sum} !== '0) begin
            bad++;
            $display("FAIL R8 idle got=%h exp=0", {cout, sum});
        end

        // R2: zero operands with both carry-ins.
        apply('0, '0, 1'b0, "R2");
        apply('0, '0, 1'b1, "R2");

        // R5: full-width ripple.
        apply('1, '0, 1'b1, "R5");
        apply('1, 64'd1, 1'b0, "R5");
        apply('1, '1, 1'b1, "R5");

        // R9: alternating patterns.
        for (int c = 0; c < 2; c++) begin
            apply({32{2'b10}}, {32{2'b01}}, c[0], "R9");
            apply({32{2'b10}}, {32{2'b10}}, c[0], "R9");
            apply({32{2'b01}}, {32{2'b01}}, c[0], "R9");
        end

        // R3: carry launched just below every group boundary.
        for (int i = 2; i < W; i += 3) begin
            apply((64'd1 << i) - 64'd1, 64'd1, 1'b0, "R3");
            apply((64'd1 << i) - 64'd1, '0, 1'b1, "R3");
            apply((64'd1 << i) - 64'd1, (64'd1 << i) - 64'd1, 1'b0, "R3");
        end

        // R7: top group and carry-out.
        apply(64'd1 << 63, 64'd1 << 63, 1'b0, "R7");
        apply(64'd3 << 62, 64'd1 << 62, 1'b1, "R7");
        apply(64'd1 << 62, 64'd1 << 62, 1'b0, "R7");

        // R4: complementary operands.
        for (int n = 0; n < 8; n++) begin
            logic [W-1:0] r;
            r = rnd64();
            apply(r, ~r, n[0], "R4");
        end

        // R6: low bits fixed, upper bits vary; the full result is compared.
        for (int n = 0; n < 8; n++) begin
            apply({rnd64() >> 2, 2'b11}, {rnd64() >> 2, 2'b01}, n[0], "R6");
        end

        // R1: random vectors with both carry-ins.
        for (int n = 0; n < 200; n++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = rnd64();
            rb = rnd64();
            apply(ra, rb, 1'b0, "R1");
            apply(ra, rb, 1'b1, "R1");
        end

        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule